// File: doc/BRIEF.md
# Multi-lane SPI command master

This block is a half-duplex SPI master that runs one framed transaction at a time. A transaction always begins with an 8-bit opcode and a 24-bit device address. A data phase of programmable byte length follows. The opcode byte sets two things: whether the data phase is a write or a read, and whether it runs on one, two or four lanes. The opcode and address always leave on a single lane. Only the data phase widens.

The host side starts a transaction with a one-cycle `start` pulse. It presents the opcode, address and byte count alongside that pulse. It then watches `busy` and `done`. Write data is pulled byte by byte through a valid/ready stream. Read data is pushed out as one-cycle byte strobes.

On the pad side the block drives SCLK in mode 0, an active-low chip select, and four IO lanes. Each lane has a separate output value, output enable and input. The pad cell merges these into a bidirectional pin. SCLK runs at the system clock divided by twice the `HALF_DIV` parameter.

Top module: `spi_lane_master`

## Requirements
- R1: The opcode selects the data-phase mode: 0x02 single-lane write, 0xB2 dual-lane write, 0xE2 quad-lane write, 0x0B single-lane read, 0xBB dual-lane read, 0xEB quad-lane read. The data phase lasts 8, 4 or 2 SCLK periods per byte for one, two or four lanes.
- R2: Any other opcode on `start` produces `done` and `op_err` together for one cycle, in the cycle after `start`. `cs_n` never goes low.
- R3: The first 32 SCLK periods carry the opcode and then the address, most significant bit first, on `io_o[0]`. Only `io_oe[0]` is set during these periods.
- R4: SCLK is low whenever `cs_n` is high. Outputs change only while SCLK is low, and the device samples them on the SCLK rising edge. Each SCLK half period lasts `HALF_DIV` clocks.
- R5: In a write data phase, bits leave most significant first. Single mode uses `io_o[0]` only. Dual mode puts the higher bit of each pair on `io_o[1]`. Quad mode puts bits 7..4 and then 3..0 on `io_o[3:0]`. Exactly the used lanes have their enable set.
- R6: In a read data phase, all four `io_oe` bits are low. Input is sampled on the rising edge, most significant first: `io_i[1]` in single mode, `io_i[1:0]` in dual mode, `io_i[3:0]` in quad mode. Each completed byte appears on `rx_data` with a one-cycle `rx_valid`. `rx_valid` never rises on a write.
- R7: `busy` is high from the cycle after an accepted `start` until `done`. `cs_n` stays low from the first opcode bit until after the last data bit. `done` pulses for one cycle, in the same cycle that `cs_n` returns high.
- R8: A byte count of zero gives a transaction of exactly 32 SCLK periods: opcode and address only.
- R9: Each write data byte is taken from `tx_data` in a cycle where both `tx_ready` and `tx_valid` are high. Exactly one byte is taken per counted byte. While `tx_ready` waits for `tx_valid`, SCLK stays low.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running transaction continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transaction |
| opcode | input | 8 | Command byte, sampled with `start` |
| addr | input | 24 | Device address, sampled with `start` |
| byte_cnt | input | CNT_W | Data-phase length in bytes, sampled with `start` |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction strobe |
| op_err | output | 1 | One-cycle strobe for an unrecognised opcode |
| tx_data | input | 8 | Write data byte |
| tx_valid | input | 1 | Write data byte available |
| tx_ready | output | 1 | Master is waiting for a write byte |
| rx_data | output | 8 | Read data byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| io_o | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_i | input | 4 | Lane input values |

## Verification
Some rules can be judged from a single cycle or one cycle back, and assertions check these on every cycle:
- SCLK is low while the chip select is released.
- Outputs hold steady across an SCLK high period.
- Only lane 0 is driven during the header.
- Nothing is driven in a read data phase.
- SCLK is held low while waiting for a transmit byte.
- A rejected opcode leaves the bus idle.

Whole-transaction properties need the bench's scenarios and its device model:
- the exact bit order of the opcode and address;
- the mapping of bytes onto two or four lanes in both directions;
- the data-phase length for each opcode;
- the zero-length case;
- stalls on the transmit stream;
- the handling of a `start` repeated mid-transaction.

// File: rtl/spi_lane_pkg.sv
package spi_lane_pkg;

  typedef enum logic [1:0] {LN_1 = 2'd0, LN_2 = 2'd1, LN_4 = 2'd2} lane_e;

  typedef struct packed {
    logic  ok;
    logic  rd;
    lane_e ln;
  } op_info_t;

  function automatic op_info_t decode_op(input logic [7:0] op);
    op_info_t r;
    r.ok = 1'b1;
    r.rd = 1'b0;
    r.ln = LN_1;
    case (op)
      8'h02: r.ln = LN_1;
      8'hB2: r.ln = LN_2;
      8'hE2: r.ln = LN_4;
      8'h0B: r.rd = 1'b1;
      8'hBB: begin r.rd = 1'b1; r.ln = LN_2; end
      8'hEB: begin r.rd = 1'b1; r.ln = LN_4; end
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

  // number of lanes carrying data
  function automatic logic [2:0] lane_count(input lane_e ln);
    case (ln)
      LN_1:    return 3'd1;
      LN_2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // SCLK periods per byte, minus one
  function automatic logic [2:0] beats_m1(input lane_e ln);
    case (ln)
      LN_1:    return 3'd7;
      LN_2:    return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [7:0] shift_out(input logic [7:0] sr, input lane_e ln);
    case (ln)
      LN_1:    return {sr[6:0], 1'b0};
      LN_2:    return {sr[5:0], 2'b0};
      default: return {sr[3:0], 4'b0};
    endcase
  endfunction

  function automatic logic [7:0] shift_in(input logic [7:0] sr, input lane_e ln,
                                          input logic [3:0] io);
    case (ln)
      LN_1:    return {sr[6:0], io[1]};
      LN_2:    return {sr[5:0], io[1:0]};
      default: return {sr[3:0], io[3:0]};
    endcase
  endfunction

  // address byte sent when sel address bytes remain
  function automatic logic [7:0] addr_byte(input logic [23:0] a, input logic [1:0] sel);
    case (sel)
      2'd3:    return a[23:16];
      2'd2:    return a[15:8];
      default: return a[7:0];
    endcase
  endfunction

endpackage

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] cnt;
  logic          term;

  assign term = run && (cnt == DW'(HALF_DIV - 1));
  assign rise = term && !sclk;
  assign fall = term && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (term) begin
      cnt  <= '0;
      sclk <= !sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_lane_map.sv
module spi_lane_map
  import spi_lane_pkg::*;
(
  input  logic [7:0] sr,
  input  lane_e      ln,
  input  logic       hdr,
  input  logic       drive,
  output logic [3:0] io_o,
  output logic [3:0] io_oe
);
  logic [2:0] width;
  logic [3:0] pat;

  always_comb begin
    width = hdr ? 3'd1 : lane_count(ln);
    if (hdr || ln == LN_1) pat = {3'b000, sr[7]};
    else if (ln == LN_2)   pat = {2'b00, sr[7:6]};
    else                   pat = sr[7:4];
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign io_oe[g] = drive && (3'(g) < width);
    assign io_o[g]  = io_oe[g] && pat[g];
  end

endmodule

// File: rtl/spi_lane_master.sv
module spi_lane_master
  import spi_lane_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [23:0]      addr,
  input  logic [CNT_W-1:0] byte_cnt,
  output logic             busy,
  output logic             done,
  output logic             op_err,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             sclk,
  output logic             cs_n,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_i
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FETCH, ST_FIN} state_e;

  state_e           state;
  op_info_t         dec;
  logic [7:0]       sr;
  logic [23:0]      addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rd_q, in_data;
  lane_e            ln_q;
  logic [1:0]       hdr_left;
  logic [2:0]       bcnt;

  // named events for the assertions
  logic run_w, rise_w, fall_w, hdr_phase_w, rd_phase_w, drive_w;

  assign dec         = decode_op(opcode);
  assign run_w       = (state == ST_RUN);
  assign hdr_phase_w = run_w && !in_data;
  assign rd_phase_w  = run_w && in_data && rd_q;
  assign drive_w     = run_w && !(in_data && rd_q);
  assign busy        = (state != ST_IDLE);
  assign tx_ready    = (state == ST_FETCH);

  spi_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run_w),
    .sclk(sclk), .rise(rise_w), .fall(fall_w)
  );

  spi_lane_map u_map (
    .sr(sr), .ln(ln_q), .hdr(!in_data), .drive(drive_w),
    .io_o(io_o), .io_oe(io_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      op_err   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      sr       <= '0;
      addr_q   <= '0;
      cnt_q    <= '0;
      rd_q     <= 1'b0;
      in_data  <= 1'b0;
      ln_q     <= LN_1;
      hdr_left <= '0;
      bcnt     <= '0;
    end else begin
      done     <= 1'b0;
      op_err   <= 1'b0;
      rx_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (!dec.ok) begin
              done   <= 1'b1;
              op_err <= 1'b1;
            end else begin
              state    <= ST_RUN;
              cs_n     <= 1'b0;
              sr       <= opcode;
              addr_q   <= addr;
              cnt_q    <= byte_cnt;
              rd_q     <= dec.rd;
              ln_q     <= dec.ln;
              in_data  <= 1'b0;
              hdr_left <= 2'd3;
              bcnt     <= 3'd7;
            end
          end
        end
        ST_RUN: begin
          if (rise_w && in_data && rd_q) sr <= shift_in(sr, ln_q, io_i);
          if (fall_w) begin
            if (bcnt != 3'd0) begin
              bcnt <= bcnt - 3'd1;
              if (!in_data)   sr <= shift_out(sr, LN_1);
              else if (!rd_q) sr <= shift_out(sr, ln_q);
            end else if (!in_data) begin
              if (hdr_left != 2'd0) begin
                sr       <= addr_byte(addr_q, hdr_left);
                hdr_left <= hdr_left - 2'd1;
                bcnt     <= 3'd7;
              end else if (cnt_q == '0) begin
                state <= ST_FIN;
              end else begin
                in_data <= 1'b1;
                bcnt    <= beats_m1(ln_q);
                if (rd_q) sr <= '0;
                else      state <= ST_FETCH;
              end
            end else begin
              if (rd_q) begin
                rx_valid <= 1'b1;
                rx_data  <= sr;
              end
              cnt_q <= cnt_q - 1'b1;
              if (cnt_q == CNT_W'(1)) begin
                state <= ST_FIN;
              end else begin
                bcnt <= beats_m1(ln_q);
                if (!rd_q) state <= ST_FETCH;
              end
            end
          end
        end
        ST_FETCH: begin
          if (tx_valid) begin
            sr    <= tx_data;
            state <= ST_RUN;
          end
        end
        default: begin
          cs_n    <= 1'b1;
          done    <= 1'b1;
          in_data <= 1'b0;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);  // R4
  AST_IO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> ($stable(io_o) && $stable(io_oe)));  // R4
  AST_HDR_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_phase_w |-> (io_oe == 4'b0001));  // R3
  AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase_w |-> (io_oe == 4'b0000));  // R6
  AST_RX_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rd_q);  // R6
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> (cs_n && $past(cs_n) && done));  // R2
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));  // R7
  AST_FETCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !sclk);  // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(addr_q));  // R10

endmodule

// File: tb/sim_spi_lane_master.sv
`timescale 1ns/1ps
module sim_spi_lane_master;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] opcode = '0;
  logic [23:0] addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic busy, done, op_err, tx_ready, rx_valid, sclk, cs_n;
  logic [7:0] tx_data, rx_data;
  logic tx_valid = 1'b1;
  logic [3:0] io_o, io_oe, io_i;

  always #2.5 clk = ~clk;

  spi_lane_master #(.HALF_DIV(2), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .addr(addr),
    .byte_cnt(byte_cnt), .busy(busy), .done(done), .op_err(op_err),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .cs_n(cs_n),
    .io_o(io_o), .io_oe(io_oe), .io_i(io_i)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];
  logic [7:0] rx_got [16];
  int cur_L = 1;
  bit cur_rd = 0, stall_en = 0;
  logic [7:0] cur_op = '0;
  logic [23:0] cur_addr = '0;
  int tx_idx = 0, rx_n = 0, mon_k = 0, hmism = 0, dmism = 0, cs_falls = 0, dev_beat = 0;
  logic mon_clr = 1'b0;

  function automatic logic [3:0] chunk(input logic [7:0] b, input int L, input int j);
    return 4'((b >> (8 - L * (j + 1))) & ((1 << L) - 1));
  endfunction

  // expected {oe, io} at SCLK rising edge number k
  function automatic logic [7:0] exp_beat(input int k);
    logic [31:0] h;
    int d, bpb;
    h = {cur_op, cur_addr};
    if (k < 32) return {4'b0001, 3'b000, h[31-k]};
    if (cur_rd) return 8'h00;
    bpb = 8 / cur_L;
    d = k - 32;
    return {4'((1 << cur_L) - 1), chunk(tx_buf[(d / bpb) % 16], cur_L, d % bpb)};
  endfunction

  assign tx_data = tx_buf[tx_idx[3:0]];

  always @(posedge clk or posedge mon_clr)
    if (mon_clr) tx_idx <= 0;
    else if (tx_ready && tx_valid) tx_idx <= tx_idx + 1;

  always @(negedge clk) tx_valid <= stall_en ? ($urandom % 3 == 0) : 1'b1;

  always @(negedge clk or posedge mon_clr)
    if (mon_clr) rx_n <= 0;
    else if (rx_valid) begin
      rx_got[rx_n[3:0]] <= rx_data;
      rx_n <= rx_n + 1;
    end

  always @(negedge cs_n or posedge mon_clr)
    if (mon_clr) cs_falls <= 0;
    else cs_falls <= cs_falls + 1;

  // device model: advances one beat per falling SCLK edge
  always @(negedge sclk or posedge cs_n)
    if (cs_n) dev_beat <= 0;
    else dev_beat <= dev_beat + 1;

  always @* begin
    logic [3:0] ch;
    int bpb, d;
    io_i = 4'b0000;
    if (cur_rd && dev_beat >= 32) begin
      bpb = 8 / cur_L;
      d = dev_beat - 32;
      ch = chunk(rx_buf[(d / bpb) % 16], cur_L, d % bpb);
      io_i = (cur_L == 1) ? {2'b00, ch[0], 1'b0} : ch;
    end
  end

  // monitor at SCLK rising edges (R3, R4, R5, R6)
  always @(posedge sclk or posedge mon_clr)
    if (mon_clr) begin
      mon_k <= 0; hmism <= 0; dmism <= 0;
    end else begin
      logic [7:0] e;
      e = exp_beat(mon_k);
      if (io_oe !== e[7:4] || (io_o & e[7:4]) !== (e[3:0] & e[7:4])) begin
        if (mon_k < 32) hmism <= hmism + 1;
        else dmism <= dmism + 1;
      end
      mon_k <= mon_k + 1;
    end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic txn(input logic [7:0] op, input logic [23:0] a, input int n,
                     input bit stall, input bit restart);
    bit valid, got, err_seen;
    int L, beats, bad;
    valid = 1; cur_rd = 0; L = 1;
    case (op)
      8'h02: L = 1;
      8'hB2: L = 2;
      8'hE2: L = 4;
      8'h0B: begin L = 1; cur_rd = 1; end
      8'hBB: begin L = 2; cur_rd = 1; end
      8'hEB: begin L = 4; cur_rd = 1; end
      default: valid = 0;
    endcase
    for (int i = 0; i < 16; i++) begin
      tx_buf[i] = 8'($urandom);
      rx_buf[i] = 8'($urandom);
    end
    cur_L = L; cur_op = op; cur_addr = a; stall_en = stall;
    @(posedge clk); #1 mon_clr = 1'b1;
    @(posedge clk); #1 mon_clr = 1'b0;
    @(negedge clk);
    opcode = op; addr = a; byte_cnt = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (20) @(negedge clk);
      opcode = 8'hE2; addr = ~a; byte_cnt = CW'(n + 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = 0; err_seen = 0;
    for (int t = 0; t < 20000 && !got; t++) begin
      if (done) begin got = 1; err_seen = op_err; end
      else @(negedge clk);
    end
    beats = 32 + n * 8 / L;
    if (!valid) begin
      chk(got && err_seen, "R2", "done with op_err", int'(err_seen), 1);
      chk(cs_falls == 0 && mon_k == 0, "R2", "chip select activity", cs_falls, 0);
    end else begin
      chk(got && !err_seen, "R7", "done without op_err", int'(got), 1);
      chk(mon_k == beats, (n == 0) ? "R8" : "R1", "SCLK periods", mon_k, beats);
      chk(hmism == 0, "R3", "header beat mismatches", hmism, 0);
      chk(dmism == 0, cur_rd ? "R6" : "R5", "data beat mismatches", dmism, 0);
      if (cur_rd) begin
        bad = 0;
        for (int i = 0; i < n && i < 16; i++) if (rx_got[i] !== rx_buf[i]) bad++;
        chk(rx_n == n, "R6", "received byte count", rx_n, n);
        chk(bad == 0, "R6", "received byte mismatches", bad, 0);
      end else begin
        chk(tx_idx == n, "R9", "write bytes taken", tx_idx, n);
      end
      chk(cs_n && !busy && !sclk, "R4", "bus idle after done", int'(cs_n), 1);
      if (restart)
        chk(mon_k == beats && hmism == 0 && dmism == 0, "R10", "restart ignored", mon_k, beats);
    end
    stall_en = 0;
  endtask

  initial begin
    #(190000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R7 watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [6];
    void'($urandom(32'd4242));
    ops[0] = 8'h02; ops[1] = 8'hB2; ops[2] = 8'hE2;
    ops[3] = 8'h0B; ops[4] = 8'hBB; ops[5] = 8'hEB;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && io_oe == 4'b0000 && !busy && !done, "R7", "reset state", int'(busy), 0);
    // every opcode, two bytes
    for (int i = 0; i < 6; i++) txn(ops[i], 24'hA5C30F + 24'(i), 2, 0, 0);
    // zero-length write and read
    txn(8'h02, 24'h123456, 0, 0, 0);
    txn(8'hEB, 24'hFEDCBA, 0, 0, 0);
    // unknown opcodes
    txn(8'h00, 24'h000001, 3, 0, 0);
    txn(8'hFF, 24'h000002, 3, 0, 0);
    // stalled transmit stream, quad and single
    txn(8'hE2, 24'h0F0F0F, 5, 1, 0);
    txn(8'h02, 24'h00FF00, 3, 1, 0);
    // start while busy
    txn(8'hB2, 24'h3C3C3C, 4, 0, 1);
    // random mix
    for (int i = 0; i < 30; i++)
      txn(ops[$urandom % 6], 24'($urandom), int'($urandom % 7), bit'($urandom % 2), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule